// File: doc/BRIEF.md
# Interrupt, Status and Transfer Count Register Block

This block is the byte-wide register file that sits between a host processor and the sequencing logic of a SCSI host-adapter style controller. It keeps the interrupt cause, the status byte and the sequence-step byte, and a 24-bit transfer count spread over three byte addresses. A single level interrupt line follows the interrupt bit of the status byte. Internal logic asks for an interrupt by pulsing a request together with a cause code, or signals the end of a DMA transfer with its own pulse.

The host reaches the block through a simple port with a 4-bit address, separate read and write strobes and 8-bit data. Reads return data in the same cycle with no wait states; any side effect of a read takes effect on the clock edge that samples the read strobe. The transfer count has a write copy, which host writes land in, and a read copy, which host reads return; the write copy reaches the read copy only when the host issues a command with the DMA flag set. Until the top count byte has been written once after reset, reading it returns a fixed identification constant.

Address map with default parameters: 0 count low, 1 count middle, 2 count high, 3 command, 4 status, 5 interrupt cause, 6 sequence step, 7 configuration. Addresses 8 to 15 are unmapped.

Top module: `scsi_irq_count_regs`

## Requirements
- R1: A one-cycle pulse on ev_raise loads ev_cause into the interrupt cause register, sets status bit 7 and drives irq high from the next cycle; a raise while irq is already high keeps irq high and replaces the cause.
- R2: A read of address 5 returns the cause held before the read; from the next cycle the cause reads 0, status bit 7 and status bit 4 (terminal count) are clear, the sequence step reads 4 and irq is low.
- R3: The transfer count occupies addresses 0 (bits 7:0), 1 (bits 15:8) and 2 (bits 23:16); host writes to them land in the write copy and leave the values read back unchanged.
- R4: A host write to any of the three count addresses clears status bit 4.
- R5: Until address 2 has been written once since reset, a read of address 2 returns the constant CHIP_ID (default 8'h52); afterwards it returns the read copy of the high count byte.
- R6: A write to address 3 stores the command byte (read back at address 3); when its bit 7 is set, the three write-copy count bytes are copied to the read copy, and when bit 7 is clear they are not.
- R7: A pulse on ev_dma_done sets status bit 4, loads cause 8'h10, sets the sequence step to 0, zeroes the read copy of all three count bytes and drives irq high from the next cycle.
- R8: After reset every register reads 0 except the configuration register at address 7, which reads 7, address 2 reads CHIP_ID, and irq is low.
- R9: A command whose bits 6:0 equal 3 loads cause 8'h80; it raises irq only when bit 6 of the last value written to address 7 is clear (that bit is clear after reset), otherwise irq keeps its value.
- R10: When an ev_raise pulse coincides with a read of address 5, the read returns the old cause and the raise wins: the next cycle shows the new cause and irq high.
- R11: Writes to addresses 4, 5, 6 and 8 to 15 change nothing, and reads of addresses 8 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 4 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid in the same cycle as addr |
| ev_raise | input | 1 | Internal interrupt request pulse |
| ev_cause | input | 8 | Cause code loaded with ev_raise |
| ev_dma_done | input | 1 | Internal end-of-DMA pulse |
| irq | output | 1 | Level interrupt to the host |

## Verification
A wrong internal state here shows up almost at once because every register is visible at the host port: a lost interrupt bit appears on irq one cycle after the event, and a mishandled read-to-clear shows as a cause or status byte still set on the very next read. Errors in the dual count banks stay hidden until a DMA command or a read of the high byte, so the bench reads all three count bytes both before and after every copying and non-copying command, across a sweep of count values, and sweeps all 256 cause codes through raise and read-to-clear.

// File: rtl/sicr_pkg.sv
package sicr_pkg;
  localparam int BYTE_W = 8;

  // status byte bit positions
  localparam int ST_INT_BIT = 7;
  localparam int ST_TC_BIT  = 4;

  // interrupt cause codes
  localparam logic [BYTE_W-1:0] CAUSE_BUS_SVC = 8'h10;
  localparam logic [BYTE_W-1:0] CAUSE_BUS_RST = 8'h80;

  // sequence step values
  localparam logic [BYTE_W-1:0] SEQ_CMD_DONE = 8'h04;
  localparam logic [BYTE_W-1:0] SEQ_IDLE     = 8'h00;

  // command byte fields
  localparam int                CMD_DMA_BIT  = 7;
  localparam logic [6:0]        CMD_BUS_RST  = 7'h03;

  // configuration byte
  localparam int                CFG_NORPT_BIT = 6;
  localparam logic [BYTE_W-1:0] CFG_RESET_VAL = 8'h07;
endpackage

// File: rtl/sicr_decode.sv
module sicr_decode
  import sicr_pkg::*;
#(
  parameter int AW        = 4,
  parameter int CNT_BYTES = 3
) (
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [CNT_BYTES-1:0] cnt_wr,
  output logic                 cnt_wr_any,
  output logic                 cmd_wr,
  output logic                 cfg_wr,
  output logic                 cause_rd,
  output logic                 dma_cmd,
  output logic                 busrst_cmd
);
  localparam logic [AW-1:0] A_CMD   = AW'(CNT_BYTES);
  localparam logic [AW-1:0] A_CAUSE = AW'(CNT_BYTES + 2);
  localparam logic [AW-1:0] A_CFG   = AW'(CNT_BYTES + 4);

  for (genvar i = 0; i < CNT_BYTES; i++) begin : g_cnt_dec
    assign cnt_wr[i] = wr_en && (addr == AW'(i));
  end

  assign cnt_wr_any = |cnt_wr;
  assign cmd_wr     = wr_en && (addr == A_CMD);
  assign cfg_wr     = wr_en && (addr == A_CFG);
  assign cause_rd   = rd_en && (addr == A_CAUSE);
  assign dma_cmd    = cmd_wr && wdata[CMD_DMA_BIT];
  assign busrst_cmd = cmd_wr && (wdata[6:0] == CMD_BUS_RST);
endmodule

// File: rtl/sicr_count.sv
module sicr_count
  import sicr_pkg::*;
#(
  parameter int CNT_BYTES = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CNT_BYTES-1:0]        cnt_wr,
  input  logic [BYTE_W-1:0]           wdata,
  input  logic                        dma_cmd,
  input  logic                        dma_done,
  output logic [CNT_BYTES*BYTE_W-1:0] cnt_rd,
  output logic                        top_written
);
  localparam int CW = CNT_BYTES * BYTE_W;

  logic [CW-1:0] wcopy_q, wcopy_d;
  logic [CW-1:0] rcopy_q, rcopy_d;
  logic          top_q, top_d;
  logic          rcopy_en;

  always_comb begin
    wcopy_d = wcopy_q;
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (cnt_wr[i]) wcopy_d[i*BYTE_W +: BYTE_W] = wdata;
    end
  end

  assign rcopy_en = dma_done || dma_cmd;
  assign rcopy_d  = dma_done ? '0 : wcopy_q;
  assign top_d    = top_q || cnt_wr[CNT_BYTES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcopy_q <= '0;
      rcopy_q <= '0;
      top_q   <= 1'b0;
    end else begin
      if (|cnt_wr) wcopy_q <= wcopy_d;
      if (rcopy_en) rcopy_q <= rcopy_d;
      top_q <= top_d;
    end
  end

  assign cnt_rd      = rcopy_q;
  assign top_written = top_q;
endmodule

// File: rtl/sicr_irq_ctrl.sv
module sicr_irq_ctrl
  import sicr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cause_rd,
  input  logic              cnt_wr_any,
  input  logic              busrst_cmd,
  input  logic              no_report,
  input  logic              ev_raise,
  input  logic [BYTE_W-1:0] ev_cause,
  input  logic              dma_done,
  output logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] cause,
  output logic [BYTE_W-1:0] seq,
  output logic              irq
);
  logic [BYTE_W-1:0] stat_q, stat_d;
  logic [BYTE_W-1:0] cause_q, cause_d;
  logic [BYTE_W-1:0] seq_q, seq_d;
  logic              do_raise, do_lower;

  // later items override earlier ones: read effects, host writes, events
  always_comb begin
    stat_d   = stat_q;
    cause_d  = cause_q;
    seq_d    = seq_q;
    do_raise = 1'b0;
    do_lower = 1'b0;
    if (cause_rd) begin
      cause_d            = '0;
      stat_d[ST_TC_BIT]  = 1'b0;
      seq_d              = SEQ_CMD_DONE;
      do_lower           = 1'b1;
    end
    if (cnt_wr_any) stat_d[ST_TC_BIT] = 1'b0;
    if (busrst_cmd) begin
      cause_d = CAUSE_BUS_RST;
      if (!no_report) do_raise = 1'b1;
    end
    if (ev_raise) begin
      cause_d  = ev_cause;
      do_raise = 1'b1;
    end
    if (dma_done) begin
      stat_d[ST_TC_BIT] = 1'b1;
      cause_d           = CAUSE_BUS_SVC;
      seq_d             = SEQ_IDLE;
      do_raise          = 1'b1;
    end
    if (do_raise)      stat_d[ST_INT_BIT] = 1'b1;
    else if (do_lower) stat_d[ST_INT_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      cause_q <= '0;
      seq_q   <= '0;
    end else begin
      stat_q  <= stat_d;
      cause_q <= cause_d;
      seq_q   <= seq_d;
    end
  end

  assign status = stat_q;
  assign cause  = cause_q;
  assign seq    = seq_q;
  assign irq    = stat_q[ST_INT_BIT];
endmodule

// File: rtl/scsi_irq_count_regs.sv
module scsi_irq_count_regs
  import sicr_pkg::*;
#(
  parameter int                AW        = 4,
  parameter int                CNT_BYTES = 3,
  parameter logic [BYTE_W-1:0] CHIP_ID   = 8'h52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              ev_raise,
  input  logic [BYTE_W-1:0] ev_cause,
  input  logic              ev_dma_done,
  output logic              irq
);
  localparam int            CW      = CNT_BYTES * BYTE_W;
  localparam logic [AW-1:0] A_TOP   = AW'(CNT_BYTES - 1);
  localparam logic [AW-1:0] A_CMD   = AW'(CNT_BYTES);
  localparam logic [AW-1:0] A_STAT  = AW'(CNT_BYTES + 1);
  localparam logic [AW-1:0] A_CAUSE = AW'(CNT_BYTES + 2);
  localparam logic [AW-1:0] A_SEQ   = AW'(CNT_BYTES + 3);
  localparam logic [AW-1:0] A_CFG   = AW'(CNT_BYTES + 4);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [CNT_BYTES-1:0] cnt_wr;
  logic                 cnt_wr_any, cmd_wr, cfg_wr, cause_rd, dma_cmd, busrst_cmd;
  logic [CW-1:0]        cnt_rd;
  logic                 top_written;
  logic [BYTE_W-1:0]    status, cause, seq;
  logic [BYTE_W-1:0]    cmd_q, cfg_w_q, cfg_r_q;

  sicr_decode #(.AW(AW), .CNT_BYTES(CNT_BYTES)) u_decode (
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .cnt_wr     (cnt_wr),
    .cnt_wr_any (cnt_wr_any),
    .cmd_wr     (cmd_wr),
    .cfg_wr     (cfg_wr),
    .cause_rd   (cause_rd),
    .dma_cmd    (dma_cmd),
    .busrst_cmd (busrst_cmd)
  );

  sicr_count #(.CNT_BYTES(CNT_BYTES)) u_count (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cnt_wr      (cnt_wr),
    .wdata       (wdata),
    .dma_cmd     (dma_cmd),
    .dma_done    (ev_dma_done),
    .cnt_rd      (cnt_rd),
    .top_written (top_written)
  );

  sicr_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cause_rd   (cause_rd),
    .cnt_wr_any (cnt_wr_any),
    .busrst_cmd (busrst_cmd),
    .no_report  (cfg_w_q[CFG_NORPT_BIT]),
    .ev_raise   (ev_raise),
    .ev_cause   (ev_cause),
    .dma_done   (ev_dma_done),
    .status     (status),
    .cause      (cause),
    .seq        (seq),
    .irq        (irq)
  );

  // command and configuration bytes; the configuration has a written copy
  // (used by the bus-reset rule) and a readable copy with its own reset value
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmd_q   <= '0;
      cfg_w_q <= '0;
      cfg_r_q <= CFG_RESET_VAL;
    end else begin
      if (cmd_wr) cmd_q <= wdata;
      if (cfg_wr) begin
        cfg_w_q <= wdata;
        cfg_r_q <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (addr == AW'(i)) rdata = cnt_rd[i*BYTE_W +: BYTE_W];
    end
    if ((addr == A_TOP) && !top_written) rdata = CHIP_ID;
    if (addr == A_CMD)   rdata = cmd_q;
    if (addr == A_STAT)  rdata = status;
    if (addr == A_CAUSE) rdata = cause;
    if (addr == A_SEQ)   rdata = seq;
    if (addr == A_CFG)   rdata = cfg_r_q;
  end
endmodule

// File: rtl/sicr_checker.sv
module sicr_checker
  import sicr_pkg::*;
#(
  parameter int AW        = 4,
  parameter int CNT_BYTES = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [AW-1:0]     addr,
  input logic [BYTE_W-1:0] wdata,
  input logic              ev_raise,
  input logic              ev_dma_done,
  input logic              irq,
  input logic [BYTE_W-1:0] status,
  input logic              top_written,
  input logic [BYTE_W-1:0] cfg_w
);
  localparam logic [AW-1:0] A_CMD   = AW'(CNT_BYTES);
  localparam logic [AW-1:0] A_CAUSE = AW'(CNT_BYTES + 2);

  logic rd_cause, wr_cnt, wr_busrst;
  assign rd_cause  = rd_en && (addr == A_CAUSE);
  assign wr_cnt    = wr_en && (addr < AW'(CNT_BYTES));
  assign wr_busrst = wr_en && (addr == A_CMD) && (wdata[6:0] == CMD_BUS_RST);

  // R1: a request raises the line
  p_raise_sets_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_raise |=> irq);

  // R1: the line moves only for a raise, a lower or a reporting command
  p_irq_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_raise && !ev_dma_done && !rd_cause && !wr_busrst) |=> $stable(irq));

  // R2: reading the cause lowers the line
  p_cause_read_lowers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cause && !ev_raise && !ev_dma_done) |=> (!irq && !status[ST_TC_BIT]));

  // R4: count writes clear terminal count
  p_cnt_write_clears_tc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !ev_dma_done) |=> !status[ST_TC_BIT]);

  // R5: once the top byte is written the identification is gone for good
  p_top_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    top_written |=> top_written);

  // R7: end of DMA raises the line with terminal count
  p_dma_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dma_done |=> (irq && status[ST_TC_BIT]));

  // R9: bus reset reports when enabled
  p_busrst_report_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busrst && !cfg_w[CFG_NORPT_BIT]) |=> irq);

  // R1: line and status bit agree
  p_irq_status_agree_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq == status[ST_INT_BIT]);
endmodule

bind scsi_irq_count_regs sicr_checker #(.AW(AW), .CNT_BYTES(CNT_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .wdata       (wdata),
  .ev_raise    (ev_raise),
  .ev_dma_done (ev_dma_done),
  .irq         (irq),
  .status      (status),
  .top_written (top_written),
  .cfg_w       (cfg_w_q)
);

// File: tb/scsi_irq_count_regs_test.sv
module scsi_irq_count_regs_test;
  localparam logic [7:0] CHIP = 8'h52;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ev_raise = 1'b0;
  logic [7:0] ev_cause = '0;
  logic       ev_dma_done = 1'b0;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scsi_irq_count_regs uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ev_raise(ev_raise), .ev_cause(ev_cause),
    .ev_dma_done(ev_dma_done), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic raise(input logic [7:0] c);
    @(negedge clk);
    ev_raise = 1'b1; ev_cause = c;
    @(negedge clk);
    ev_raise = 1'b0;
  endtask

  task automatic dma_done();
    @(negedge clk);
    ev_dma_done = 1'b1;
    @(negedge clk);
    ev_dma_done = 1'b0;
  endtask

  task automatic irq_is(input string req, input logic exp);
    #1 check(req, {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic reset_state(input string req);
    logic [7:0] d;
    irq_is(req, 1'b0);
    rd(4'd0, d); check(req, d, 8'h00);
    rd(4'd1, d); check(req, d, 8'h00);
    rd(4'd2, d); check(req, d, CHIP);
    rd(4'd3, d); check(req, d, 8'h00);
    rd(4'd4, d); check(req, d, 8'h00);
    rd(4'd6, d); check(req, d, 8'h00);
    rd(4'd5, d); check(req, d, 8'h00);
    rd(4'd7, d); check(req, d, 8'h07);
  endtask

  initial begin
    logic [7:0] d;
    logic [7:0] er [3];
    logic [7:0] nv [3];
    do_reset();

    // R8: reset state
    reset_state("R8");

    // R1 / R2: every cause code through raise and read-to-clear
    for (int c = 0; c < 256; c++) begin
      raise(8'(c));
      irq_is("R1", 1'b1);
      rd(4'd4, d); check("R1", d, 8'h80);
      rd(4'd5, d); check("R2", d, 8'(c));
      irq_is("R2", 1'b0);
      rd(4'd5, d); check("R2", d, 8'h00);
      rd(4'd4, d); check("R2", d, 8'h00);
      rd(4'd6, d); check("R2", d, 8'h04);
    end
    // R1: second raise while high
    raise(8'h21);
    raise(8'h42);
    irq_is("R1", 1'b1);
    rd(4'd5, d); check("R1", d, 8'h42);
    irq_is("R2", 1'b0);

    // R5: identification until the top byte is written
    do_reset();
    wr(4'd0, 8'h11); wr(4'd1, 8'h22); wr(4'd3, 8'h80);
    rd(4'd2, d); check("R5", d, CHIP);
    wr(4'd2, 8'h5A);
    rd(4'd2, d); check("R5", d, 8'h00);
    wr(4'd3, 8'h80);
    rd(4'd2, d); check("R5", d, 8'h5A);
    rd(4'd0, d); check("R6", d, 8'h11);

    // R3 / R6: count sweep, copy only on DMA-flagged commands
    do_reset();
    for (int i = 0; i < 3; i++) er[i] = 8'h00;
    for (int v = 0; v < 256; v++) begin
      nv[0] = 8'(v); nv[1] = 8'(v) ^ 8'hA5; nv[2] = 8'hFF - 8'(v);
      for (int i = 0; i < 3; i++) wr(4'(i), nv[i]);
      for (int i = 0; i < 3; i++) begin rd(4'(i), d); check("R3", d, er[i]); end
      wr(4'd3, 8'h00);
      for (int i = 0; i < 3; i++) begin rd(4'(i), d); check("R6", d, er[i]); end
      wr(4'd3, 8'h80);
      for (int i = 0; i < 3; i++) er[i] = nv[i];
      for (int i = 0; i < 3; i++) begin rd(4'(i), d); check("R6", d, er[i]); end
      rd(4'd3, d); check("R6", d, 8'h80);
    end
    irq_is("R6", 1'b0);

    // R7: end of DMA
    wr(4'd0, 8'h01); wr(4'd1, 8'h02); wr(4'd2, 8'h03); wr(4'd3, 8'h80);
    rd(4'd5, d);
    dma_done();
    irq_is("R7", 1'b1);
    rd(4'd4, d); check("R7", d, 8'h90);
    rd(4'd6, d); check("R7", d, 8'h00);
    for (int i = 0; i < 3; i++) begin rd(4'(i), d); check("R7", d, 8'h00); end
    rd(4'd5, d); check("R7", d, 8'h10);

    // R4: each count byte clears terminal count
    for (int i = 0; i < 3; i++) begin
      dma_done();
      rd(4'd4, d); check("R4", d, 8'h90);
      wr(4'(i), 8'h33);
      rd(4'd4, d); check("R4", d, 8'h80);
      rd(4'd5, d);
    end

    // R9: bus reset, with and without reporting
    do_reset();
    wr(4'd3, 8'h03);
    irq_is("R9", 1'b1);
    rd(4'd5, d); check("R9", d, 8'h80);
    wr(4'd7, 8'h40);
    rd(4'd7, d); check("R9", d, 8'h40);
    wr(4'd3, 8'h03);
    irq_is("R9", 1'b0);
    rd(4'd4, d); check("R9", d, 8'h00);
    rd(4'd5, d); check("R9", d, 8'h80);
    wr(4'd7, 8'h00);
    wr(4'd0, 8'h77);
    wr(4'd3, 8'h83);
    irq_is("R9", 1'b1);
    rd(4'd0, d); check("R6", d, 8'h77);
    rd(4'd5, d);

    // R10: raise coinciding with a cause read
    raise(8'h0C);
    @(negedge clk);
    rd_en = 1'b1; addr = 4'd5; ev_raise = 1'b1; ev_cause = 8'h3E;
    #1 check("R10", rdata, 8'h0C);
    @(negedge clk);
    rd_en = 1'b0; ev_raise = 1'b0;
    irq_is("R10", 1'b1);
    rd(4'd5, d); check("R10", d, 8'h3E);

    // R11: writes to read-only and unmapped addresses
    raise(8'h55);
    wr(4'd4, 8'h00); wr(4'd5, 8'h00); wr(4'd6, 8'hFF);
    for (int a = 8; a < 16; a++) wr(4'(a), 8'hFF);
    irq_is("R11", 1'b1);
    rd(4'd4, d); check("R11", d, 8'h80);
    for (int a = 8; a < 16; a++) begin rd(4'(a), d); check("R11", d, 8'h00); end
    rd(4'd0, d); check("R11", d, 8'h77);
    rd(4'd5, d); check("R11", d, 8'h55);

    // R8: reset after activity
    raise(8'h99);
    wr(4'd2, 8'h44);
    wr(4'd7, 8'h12);
    do_reset();
    reset_state("R8");

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule